// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block holds the software-generated interrupt (SGI) state of a multi-core interrupt distributor. Each of up to eight cores owns sixteen SGI numbers. For each one the block keeps an 8-bit bitmap that records which cores raised it. An SGI is pending for a core while its bitmap has any bit set. Every core's sixteen pending flags are driven out together on one flat vector.

Software reaches the block through a simple single-cycle register port. Every access carries the ID of the core that makes it. A write to the send register raises one SGI number on a set of target cores, and a filter mode chooses that set. Two byte-addressed windows of sixteen bytes each, one for setting and one for clearing, let a core read its own bitmaps and change them directly. Each window accepts single-byte and full-word accesses. Read data is combinational and is valid in the cycle of the access. Writes take effect at the next clock edge.

Top module: `sgi_dispatch`

## Requirements
- R1: Reset, asynchronous and active low, clears every source bitmap. All pending outputs are then zero and every window read returns zero.
- R2: A write to the send region (req_addr[5:4]=0) takes the SGI number from data bits [3:0], the target list from bits [23:16] and the mode from bits [25:24]. In mode 0, each listed core gets the writer's bit ORed into that SGI's bitmap, and the SGI becomes pending there.
- R3: In send mode 1, the target set is every existing core except the writer. The target list is ignored.
- R4: In send mode 2, only the writer is targeted. The target list is ignored.
- R5: In send mode 3, the write changes no state.
- R6: Target list bits at or above NUM_CORES have no effect.
- R7: A write to the set window (req_addr[5:4]=2) ORs each written byte into the addressed bitmap of the accessing core. The SGI is pending only if the resulting bitmap is non-zero.
- R8: A write to the clear window (req_addr[5:4]=1) clears, in the addressed bitmap of the accessing core, the bits that are set in each written byte. Pending drops only when the bitmap reaches zero.
- R9: A read of either window returns the accessing core's source bitmaps.
- R10: For a byte access (req_word=0), req_addr[3:0] selects the SGI and data bits [7:0] carry its bitmap. For a word access (req_word=1), req_addr[3:2] selects a group of four SGIs, and byte lane i (bits 8i+7:8i) maps to SGI 4*req_addr[3:2]+i.
- R11: Reads of the send region, reads of the unused region (req_addr[5:4]=3) and idle cycles return zero. Writes to the unused region change nothing.
- R12: Accesses tagged with a core ID at or above NUM_CORES change nothing and read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 32-bit access, 0 = 8-bit access |
| req_core | input | 3 | ID of the accessing core |
| req_addr | input | 6 | Byte offset: [5:4] region, [3:0] SGI or group |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, combinational |
| pend_o | output | NUM_CORES*16 | Pending flag of SGI s of core c at bit 16c+s |

## Verification
The bench sends with every filter mode. Mode 0 uses target lists that name cores that do not exist, which separates list masking from the mode 1 and mode 2 overrides. Mode 3 is the case where nothing may move. Set and clear writes with zero, partial and full bytes separate "pending follows the bitmap" from "pending follows the last write". Word accesses that carry a different value in each lane expose lane swaps, and accesses from nonexistent cores and the unused region must leave both outputs untouched. Long random mixes then compare the pending vector and every read against a bench model after each access.

// File: rtl/sgi_dispatch.sv
module sgi_dispatch #(
  parameter int NUM_CORES = 8,
  parameter int ID_W      = 3,
  parameter int SRC_W     = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic                      req_word,
  input  logic [ID_W-1:0]           req_core,
  input  logic [5:0]                req_addr,
  input  logic [31:0]               req_wdata,
  output logic [31:0]               rd_data,
  output logic [NUM_CORES*16-1:0]   pend_o
);
  localparam int NSGI = 16;
  localparam logic [1:0] RG_SEND = 2'd0, RG_CLR = 2'd1, RG_SET = 2'd2;
  localparam logic [SRC_W-1:0] EXIST = SRC_W'((64'd1 << NUM_CORES) - 64'd1);

  logic [NUM_CORES*NSGI*SRC_W-1:0] src_flat;
  logic [SRC_W-1:0] writer_oh, tgt;
  logic [1:0] region, mode;
  logic core_ok, do_send, do_clr, do_set;
  logic [NSGI-1:0] hit;
  logic [7:0] bdat [NSGI];

  assign core_ok   = int'(req_core) < NUM_CORES;
  assign region    = req_addr[5:4];
  assign mode      = req_wdata[25:24];
  assign writer_oh = SRC_W'(1) << req_core;
  assign do_send   = req_valid && req_write && core_ok && region == RG_SEND;
  assign do_clr    = req_valid && req_write && core_ok && region == RG_CLR;
  assign do_set    = req_valid && req_write && core_ok && region == RG_SET;

  always_comb begin
    case (mode)
      2'd0:    tgt = req_wdata[16 +: SRC_W] & EXIST;
      2'd1:    tgt = EXIST & ~writer_oh;
      2'd2:    tgt = writer_oh;
      default: tgt = '0;
    endcase
  end

  for (genvar s = 0; s < NSGI; s++) begin : g_lane
    assign hit[s]  = req_word ? (req_addr[3:2] == 2'(s / 4)) : (req_addr[3:0] == 4'(s));
    assign bdat[s] = req_word ? req_wdata[8*(s%4) +: 8] : req_wdata[7:0];
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    for (genvar s = 0; s < NSGI; s++) begin : g_sgi
      logic [SRC_W-1:0] q;
      logic own;
      assign own = int'(req_core) == c && hit[s];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else if (do_clr && own) q <= q & ~SRC_W'(bdat[s]);
        else if (do_set && own) q <= q | SRC_W'(bdat[s]);
        else if (do_send && tgt[c] && req_wdata[3:0] == 4'(s)) q <= q | writer_oh;
      end
      assign src_flat[(c*NSGI+s)*SRC_W +: SRC_W] = q;
      assign pend_o[c*NSGI+s] = |q;
    end
  end

  always_comb begin
    rd_data = '0;
    if (req_valid && !req_write && core_ok && (region == RG_CLR || region == RG_SET)) begin
      for (int c = 0; c < NUM_CORES; c++) begin
        for (int s = 0; s < NSGI; s++) begin
          if (int'(req_core) == c && hit[s]) begin
            if (req_word) rd_data[8*(s%4) +: 8] = 8'(src_flat[(c*NSGI+s)*SRC_W +: SRC_W]);
            else          rd_data[7:0]        = 8'(src_flat[(c*NSGI+s)*SRC_W +: SRC_W]);
          end
        end
      end
    end
  end
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk #(
  parameter int NUM_CORES = 8,
  parameter int ID_W      = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_write,
  input logic                    req_word,
  input logic [ID_W-1:0]         req_core,
  input logic [5:0]              req_addr,
  input logic [31:0]             req_wdata,
  input logic [31:0]             rd_data,
  input logic [NUM_CORES*16-1:0] pend_o
);
  a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> pend_o == '0);

  a_r5_reserved_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr[5:4] == 2'd0 && req_wdata[25:24] == 2'd3) |=> $stable(pend_o));

  a_r4_self_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr[5:4] == 2'd0 && req_wdata[25:24] == 2'd2 &&
     int'(req_core) < NUM_CORES)
    |=> pend_o[int'($past(req_core))*16 + int'($past(req_wdata[3:0]))]);

  a_r8_full_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_word && req_addr[5:4] == 2'd1 && req_wdata[7:0] == 8'hFF &&
     int'(req_core) < NUM_CORES)
    |=> !pend_o[int'($past(req_core))*16 + int'($past(req_addr[3:0]))]);

  a_r11_send_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr[5:4] == 2'd0) |-> rd_data == 32'd0);

  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || req_addr[5:4] == 2'd3) |=> $stable(pend_o));

  a_r12_foreign_core: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && int'(req_core) >= NUM_CORES) |=> $stable(pend_o));
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_CORES(NUM_CORES), .ID_W(ID_W)) u_chk (.*);

// File: tb/sgi_dispatch_test.sv
module sgi_dispatch_test;
  localparam int NC = 6;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, req_word = 0;
  logic [2:0] req_core = 0;
  logic [5:0] req_addr = 0;
  logic [31:0] req_wdata = 0, rd_data;
  logic [NC*16-1:0] pend_o;
  logic [7:0] mdl [8][16];
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  sgi_dispatch #(.NUM_CORES(NC)) uut (.*);

  function automatic logic [NC*16-1:0] exp_pend();
    logic [NC*16-1:0] v;
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < 16; s++) v[c*16+s] = mdl[c][s] != 0;
    return v;
  endfunction

  function automatic logic [31:0] exp_read(bit word, logic [5:0] a, logic [2:0] core);
    logic [31:0] r = 0;
    if (core >= NC || !(a[5:4] == 1 || a[5:4] == 2)) return 0;
    if (word) for (int i = 0; i < 4; i++) r[8*i +: 8] = mdl[core][a[3:2]*4+i];
    else r[7:0] = mdl[core][a[3:0]];
    return r;
  endfunction

  function automatic string tag_of(bit wr, logic [5:0] a, logic [2:0] core, logic [31:0] d);
    if (core >= NC) return "R12";
    if (a[5:4] == 3 || (!wr && a[5:4] == 0)) return "R11";
    if (!wr) return "R9";
    if (a[5:4] == 1) return "R8";
    if (a[5:4] == 2) return "R7";
    case (d[25:24]) 0: return "R2"; 1: return "R3"; 2: return "R4"; default: return "R5"; endcase
  endfunction

  task automatic model_write(bit word, logic [5:0] a, logic [2:0] core, logic [31:0] d);
    logic [7:0] tg, me;
    if (core >= NC) return;
    me = 8'd1 << core;
    case (a[5:4])
      0: begin
        case (d[25:24])
          0: tg = d[23:16];
          1: tg = ~me;
          2: tg = me;
          default: tg = 0;
        endcase
        for (int c = 0; c < NC; c++) if (tg[c]) mdl[c][d[3:0]] |= me;
      end
      1, 2: for (int i = 0; i < 4; i++) begin
        int s;
        logic [7:0] b;
        if (!word && i > 0) break;
        s = word ? a[3:2]*4 + i : int'(a[3:0]);
        b = word ? d[8*i +: 8] : d[7:0];
        if (a[5:4] == 1) mdl[core][s] &= ~b; else mdl[core][s] |= b;
      end
      default: ;
    endcase
  endtask

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(bit wr, bit word, logic [5:0] a, logic [2:0] core, logic [31:0] d);
    string t = tag_of(wr, a, core, d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_word = word; req_addr = a; req_core = core; req_wdata = d;
    #1;
    if (!wr) check(t, 128'(rd_data), 128'(exp_read(word, a, core)));
    @(posedge clk); #1;
    req_valid = 0;
    if (wr) model_write(word, a, core, d);
    check(t, 128'(pend_o), 128'(exp_pend()));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5617));
    for (int c = 0; c < 8; c++) for (int s = 0; s < 16; s++) mdl[c][s] = 0;
    repeat (3) @(posedge clk);
    #1 check("R1", 128'(pend_o), 0);
    rst_n = 1;
    op(0, 1, 6'h20, 0, 0);                 // R1 window empty after reset
    op(1, 0, 6'h00, 1, 32'h00C5_0005);     // R2 list 0xC5, bits 6,7 dropped (R6)
    op(0, 1, 6'h14, 0, 0);                 // R9 clear window read, sgi5 in lane 1
    op(0, 1, 6'h24, 2, 0);                 // R9 set window read
    op(1, 0, 6'h00, 3, 32'h01FF_0009);     // R3 all but self
    op(1, 0, 6'h00, 4, 32'h0200_000F);     // R4 self only
    op(1, 0, 6'h00, 0, 32'h03FF_0002);     // R5 reserved
    op(1, 0, 6'h23, 2, 32'h0000_0000);     // R7 zero byte keeps not pending
    op(1, 0, 6'h23, 2, 32'h0000_0081);     // R7 set
    op(1, 0, 6'h13, 2, 32'h0000_0001);     // R8 partial clear stays pending
    op(1, 0, 6'h13, 2, 32'h0000_0080);     // R8 last bit clears pending
    op(1, 1, 6'h28, 5, 32'h0403_0201);     // R10 word lanes to sgis 8..11
    op(0, 0, 6'h1A, 5, 0);                 // R10 byte read of sgi 10
    op(0, 1, 6'h2B, 5, 0);                 // R10 word read ignores addr[1:0]
    op(0, 1, 6'h00, 5, 0);                 // R11 send reads zero
    op(1, 1, 6'h30, 5, 32'hFFFF_FFFF);     // R11 unused region write
    op(0, 1, 6'h34, 5, 0);                 // R11 unused region read
    op(1, 0, 6'h00, 7, 32'h0200_0003);     // R12 nonexistent core send
    op(1, 1, 6'h20, 6, 32'hFFFF_FFFF);     // R12 nonexistent core set
    op(0, 1, 6'h20, 6, 0);                 // R12 reads zero
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] d = $urandom;
      logic [5:0] a = 6'($urandom);
      if ($urandom % 4 == 0) d[7:0] = 8'hFF;
      op(1'($urandom), 1'($urandom), a, 3'($urandom), d);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule